// File: doc/BRIEF.md
# Asynchronous DRAM Read Sequencer

This block turns single-word read requests from a synchronous valid/ready port into strobe sequences for a classic asynchronous DRAM of 256K bytes. The DRAM has a shared 9-bit multiplexed address bus. Each request carries an 18-bit word address. The block places the upper nine bits on the bus under a falling row strobe, then places the lower nine bits under a falling column strobe. It captures the byte that the DRAM drives and presents it with a one-cycle valid pulse. The write enable is never asserted. The output enable is held high whenever no data is wanted, so the memory's data pins stay released.

Each request selects one of two strobe orderings:

- **Early read:** the output enable falls during the row phase, before the column strobe. The byte is taken a fixed access count after the column strobe falls.
- **Late read:** the column strobe falls first, and the output enable falls a programmable number of cycles later. The byte is taken a fixed output-delay count after that.

Every timing count is a parameter. The row strobe is guaranteed a minimum high time between any two accesses.

Refresh is done with row-only cycles, which are dummy reads that restore one row each. An internal interval timer raises a pending refresh. That refresh is served at the next gap between accesses, ahead of any waiting request. A running row pointer steps through all 512 rows and wraps.

The request port follows these back-pressure rules:

- A read transfers on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high only while the sequencer is idle, precharged and has no refresh waiting.
- The requester must hold `req_valid`, `req_addr` and `req_late` steady until the transfer.
- Only one read is in flight at a time.
- There is no back-pressure on the result: `rdata` is valid only in the cycle where `rdata_valid` is high.

Top module: `dram_rd_ctrl`

## Requirements
- R1: While `rst_n` is low, `dram_ras_n`, `dram_cas_n`, `dram_oe_n` and `dram_we_n` are 1, and `rdata_valid` is 0.
- R2: The row strobe falls with `req_addr[17:9]` on `dram_addr`. The column strobe falls with `req_addr[8:0]` on `dram_addr`. `dram_addr` stays stable while the column strobe is low, and the column strobe is low only while the row strobe is low.
- R3: For an early read (`req_late`=0), `dram_oe_n` is already 0 when the column strobe falls. `rdata` is taken from `dram_dq` on the T_CAC-th clock edge after the column strobe falls.
- R4: For a late read (`req_late`=1), `dram_oe_n` is 1 when the column strobe falls and falls T_CTO cycles later. `rdata` is taken on the T_OE-th clock edge after `dram_oe_n` falls.
- R5: `dram_we_n` is always 1. `dram_oe_n` is 0 only while `dram_ras_n` is 0.
- R6: `rdata_valid` is a single-cycle pulse carrying the read byte. In that cycle `dram_ras_n`, `dram_cas_n` and `dram_oe_n` are all 1.
- R7: `req_ready` falls in the cycle after a transfer and stays low until the read completes.
- R8: Between two falling edges of the row strobe, `dram_ras_n` stays high for at least T_RP cycles. This also applies to the first access after reset.
- R9: A refresh is raised once every REF_INTERVAL cycles. It is a row-only cycle: the row strobe is low for T_RCD+T_CAC cycles while the column strobe and `dram_oe_n` stay high.
- R10: The refresh row starts at 0 after reset and increments by one for each refresh, modulo 512 (511 is followed by 0).
- R11: A pending refresh is served before a waiting read, but only between accesses. Under a continuous read load, refresh starts stay within a bounded distance of the REF_INTERVAL period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Sequencer can take a read |
| req_addr | input | 18 | Word address: row in [17:9], column in [8:0] |
| req_late | input | 1 | 1 selects late-read ordering, 0 early-read |
| rdata_valid | output | 1 | One-cycle pulse: `rdata` holds the read byte |
| rdata | output | 8 | Read byte |
| dram_addr | output | 9 | Multiplexed row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low (held high) |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq | input | 8 | Data from the DRAM |

## Verification
The expiry of the refresh interval can land in the same cycle as a read request arriving at an idle, precharged sequencer. Whether the refresh or the read takes that slot decides both the refresh spacing and the read's latency. The bench provokes the collision by keeping a stream of back-to-back reads, with orderings mixed, queued across many refresh intervals. A behavioural DRAM in the bench releases data only after the correct access or output-enable count. Each collision is judged by three things: the returned bytes, the spacing of refresh row-strobe falls (which must stay within a bounded window around the interval), and an unbroken, wrapping sequence of refreshed rows.

// File: rtl/dram_rd_pkg.sv
package dram_rd_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ROW,
    SEQ_COL,
    SEQ_OUT,
    SEQ_REF
  } seq_t;

  typedef enum logic [1:0] {
    BUS_ROW,
    BUS_COL,
    BUS_REF
  } bus_sel_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int INTERVAL = 780,
  parameter int A_W      = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_start,
  input  logic           ref_done,
  output logic           ref_pend,
  output logic [A_W-1:0] ref_row
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)
        ref_pend <= 1'b1;
      else if (ref_start)
        ref_pend <= 1'b0;
      if (ref_done)
        ref_row <= ref_row + 1'b1;
    end
  end
endmodule

// File: rtl/dram_prech_guard.sv
module dram_prech_guard #(
  parameter int T_RP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_active,
  output logic pre_ok
);
  localparam int PW = $clog2(T_RP + 1);

  logic [PW-1:0] cnt;

  assign pre_ok = (cnt >= PW'(T_RP - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (ras_active)
      cnt <= '0;
    else if (cnt != PW'(T_RP - 1))
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux import dram_rd_pkg::*; #(
  parameter int A_W = 9
) (
  input  bus_sel_t       sel,
  input  logic [A_W-1:0] row,
  input  logic [A_W-1:0] col,
  input  logic [A_W-1:0] ref_row,
  output logic [A_W-1:0] bus
);
  always_comb begin
    case (sel)
      BUS_COL: bus = col;
      BUS_REF: bus = ref_row;
      default: bus = row;
    endcase
  end
endmodule

// File: rtl/dram_rd_ctrl.sv
module dram_rd_ctrl import dram_rd_pkg::*; #(
  parameter int A_W          = 9,
  parameter int D_W          = 8,
  parameter int T_RP         = 3,
  parameter int T_RCD        = 2,
  parameter int T_CAC        = 3,
  parameter int T_CTO        = 1,
  parameter int T_OE         = 2,
  parameter int REF_INTERVAL = 780
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2*A_W-1:0] req_addr,
  input  logic             req_late,
  output logic             rdata_valid,
  output logic [D_W-1:0]   rdata,
  output logic [A_W-1:0]   dram_addr,
  output logic             dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic             dram_oe_n,
  input  logic [D_W-1:0]   dram_dq
);
  localparam int WMAX = max2(max2(T_RCD, T_CAC), max2(max2(T_CTO, T_OE), T_RCD + T_CAC));
  localparam int WCW  = $clog2(WMAX + 1);

  seq_t           st;
  logic [WCW-1:0] wcnt;
  logic           late_q;
  logic [A_W-1:0] row_q;
  logic [A_W-1:0] col_q;
  logic [A_W-1:0] ref_row;
  logic           ref_pend;
  logic           pre_ok;
  logic           idle;
  logic           wait_done;
  logic           ref_start;
  logic           ref_done;
  logic           capture;
  logic           accept;
  bus_sel_t       bus_sel;

  assign idle      = (st == SEQ_IDLE);
  assign wait_done = (wcnt == '0);
  assign ref_start = idle && pre_ok && ref_pend;
  assign ref_done  = (st == SEQ_REF) && wait_done;
  assign req_ready = idle && pre_ok && !ref_pend;
  assign accept    = req_valid && req_ready;
  assign capture   = wait_done && (((st == SEQ_COL) && !late_q) || (st == SEQ_OUT));

  dram_ref_timer #(.INTERVAL(REF_INTERVAL), .A_W(A_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_start(ref_start), .ref_done(ref_done),
    .ref_pend(ref_pend), .ref_row(ref_row)
  );

  dram_prech_guard #(.T_RP(T_RP)) u_pre (
    .clk(clk), .rst_n(rst_n), .ras_active(!idle), .pre_ok(pre_ok)
  );

  always_comb begin
    case (st)
      SEQ_REF:          bus_sel = BUS_REF;
      SEQ_COL, SEQ_OUT: bus_sel = BUS_COL;
      default:          bus_sel = BUS_ROW;
    endcase
  end

  dram_addr_mux #(.A_W(A_W)) u_mux (
    .sel(bus_sel), .row(row_q), .col(col_q), .ref_row(ref_row), .bus(dram_addr)
  );

  // Strobes decoded from the registered sequencer state.
  assign dram_ras_n = idle;
  assign dram_cas_n = !((st == SEQ_COL) || (st == SEQ_OUT));
  assign dram_oe_n  = !((st == SEQ_OUT) || (!late_q && ((st == SEQ_ROW) || (st == SEQ_COL))));
  assign dram_we_n  = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= SEQ_IDLE;
      wcnt        <= '0;
      late_q      <= 1'b0;
      row_q       <= '0;
      col_q       <= '0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      rdata_valid <= 1'b0;
      if (capture) begin
        rdata       <= dram_dq;
        rdata_valid <= 1'b1;
      end
      case (st)
        SEQ_IDLE: begin
          if (ref_start) begin
            st     <= SEQ_REF;
            late_q <= 1'b0;
            wcnt   <= WCW'(T_RCD + T_CAC - 1);
          end else if (accept) begin
            st     <= SEQ_ROW;
            row_q  <= req_addr[2*A_W-1:A_W];
            col_q  <= req_addr[A_W-1:0];
            late_q <= req_late;
            wcnt   <= WCW'(T_RCD - 1);
          end
        end
        SEQ_ROW: begin
          if (wait_done) begin
            st   <= SEQ_COL;
            wcnt <= late_q ? WCW'(T_CTO - 1) : WCW'(T_CAC - 1);
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        SEQ_COL: begin
          if (wait_done) begin
            if (late_q) begin
              st   <= SEQ_OUT;
              wcnt <= WCW'(T_OE - 1);
            end else begin
              st <= SEQ_IDLE;
            end
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        SEQ_OUT, SEQ_REF: begin
          if (wait_done)
            st <= SEQ_IDLE;
          else
            wcnt <= wcnt - 1'b1;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_rd_ctrl_chk.sv
module dram_rd_ctrl_chk #(
  parameter int A_W  = 9,
  parameter int T_RP = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           rdata_valid,
  input logic [A_W-1:0] dram_addr,
  input logic           dram_ras_n,
  input logic           dram_cas_n,
  input logic           dram_oe_n
);
  int hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      hi_cnt <= 0;
    else if (!dram_ras_n)
      hi_cnt <= 0;
    else if (hi_cnt < T_RP)
      hi_cnt <= hi_cnt + 1;
  end

  assert_cas_in_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  assert_col_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));

  assert_oe_in_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> !dram_ras_n);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |=> !rdata_valid);

  assert_idle_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> (dram_ras_n && dram_cas_n && dram_oe_n));

  assert_busy_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_precharge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_cnt >= T_RP));
endmodule

bind dram_rd_ctrl dram_rd_ctrl_chk #(.A_W(A_W), .T_RP(T_RP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rdata_valid(rdata_valid), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
  .dram_cas_n(dram_cas_n), .dram_oe_n(dram_oe_n)
);

// File: tb/sim_dram_rd_ctrl.sv
`timescale 1ns/1ps
module sim_dram_rd_ctrl;
  localparam int T_RP  = 3;
  localparam int T_RCD = 2;
  localparam int T_CAC = 3;
  localparam int T_CTO = 1;
  localparam int T_OE  = 2;
  localparam int REF   = 60;
  localparam int SLACK = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [17:0] req_addr = '0;
  logic        req_late = 1'b0;
  logic        rdata_valid;
  logic [7:0]  rdata;
  logic [8:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
  logic [7:0]  dram_dq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dram_rd_ctrl #(.T_RP(T_RP), .T_RCD(T_RCD), .T_CAC(T_CAC), .T_CTO(T_CTO),
                 .T_OE(T_OE), .REF_INTERVAL(REF)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_late(req_late), .rdata_valid(rdata_valid),
    .rdata(rdata), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq(dram_dq)
  );

  function automatic logic [7:0] pat(input logic [8:0] r, input logic [8:0] c);
    logic [7:0] v;
    v = (r[7:0] * 8'd5) ^ c[7:0] ^ {c[8], r[8], 6'b0};
    if (v == 8'h00) v = 8'hC3;
    return v;
  endfunction

  // Behavioural DRAM: released pins read as 0, data only after the access counts.
  logic       prev_ras = 1'b1, prev_cas = 1'b1, prev_oe = 1'b1;
  int         hi_cnt, cas_cnt, oe_cnt, cyc, fall_cyc, last_ref_fall;
  int         ref_cnt, ref_err, pre_viol, we_viol, oe_viol, max_gap, min_gap;
  logic [8:0] cur_row, acc_row, acc_col, last_ref_row;
  logic       acc_early, cas_then_oe, cas_seen, oe_seen, late_mode, seen_any, wrapped;

  always @(posedge clk) begin
    if (!rst_n) begin
      prev_ras <= 1'b1; prev_cas <= 1'b1; prev_oe <= 1'b1;
      hi_cnt <= 0; cas_cnt <= 0; oe_cnt <= 0; cyc <= 0; fall_cyc <= 0;
      last_ref_fall <= 0; ref_cnt <= 0; ref_err <= 0; pre_viol <= 0;
      we_viol <= 0; oe_viol <= 0; max_gap <= 0; min_gap <= 1000000;
      cur_row <= '0; acc_row <= '0; acc_col <= '0; last_ref_row <= '0;
      acc_early <= 1'b0; cas_then_oe <= 1'b0; cas_seen <= 1'b0;
      oe_seen <= 1'b0; late_mode <= 1'b0; seen_any <= 1'b0; wrapped <= 1'b0;
    end else begin
      cyc <= cyc + 1;
      if (!dram_we_n) we_viol <= we_viol + 1;
      if (dram_ras_n && !dram_oe_n) oe_viol <= oe_viol + 1;
      hi_cnt  <= dram_ras_n ? hi_cnt + 1 : 0;
      cas_cnt <= !dram_cas_n ? cas_cnt + 1 : 0;
      oe_cnt  <= !dram_oe_n ? oe_cnt + 1 : 0;
      if (prev_ras && !dram_ras_n) begin
        cur_row <= dram_addr;
        fall_cyc <= cyc;
        if (seen_any && hi_cnt < T_RP) pre_viol <= pre_viol + 1;
        seen_any <= 1'b1;
        cas_seen <= 1'b0;
        oe_seen <= !dram_oe_n;
        cas_then_oe <= 1'b0;
      end
      if (prev_cas && !dram_cas_n) begin
        acc_row <= cur_row;
        acc_col <= dram_addr;
        acc_early <= !dram_oe_n;
        late_mode <= dram_oe_n;
        cas_seen <= 1'b1;
      end
      if (prev_oe && !dram_oe_n) begin
        oe_seen <= 1'b1;
        if (!dram_cas_n && !prev_cas) cas_then_oe <= 1'b1;
      end
      if (!prev_ras && dram_ras_n && !cas_seen) begin
        ref_cnt <= ref_cnt + 1;
        if (oe_seen) ref_err <= ref_err + 1;
        if (cyc - fall_cyc != T_RCD + T_CAC) ref_err <= ref_err + 1;
        if (ref_cnt == 0) begin
          if (cur_row != 9'd0) ref_err <= ref_err + 1;
        end else begin
          if (cur_row != last_ref_row + 9'd1) ref_err <= ref_err + 1;
          if (cur_row == 9'd0) wrapped <= 1'b1;
          if (fall_cyc - last_ref_fall > max_gap) max_gap <= fall_cyc - last_ref_fall;
          if (fall_cyc - last_ref_fall < min_gap) min_gap <= fall_cyc - last_ref_fall;
        end
        last_ref_row <= cur_row;
        last_ref_fall <= fall_cyc;
      end
      prev_ras <= dram_ras_n;
      prev_cas <= dram_cas_n;
      prev_oe  <= dram_oe_n;
    end
  end

  assign dram_dq = (!dram_ras_n && !dram_cas_n && !dram_oe_n &&
                    (late_mode ? (oe_cnt >= T_OE - 1) : (cas_cnt >= T_CAC - 1)))
                   ? pat(cur_row, acc_col) : 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [17:0] a, input logic late);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_late = late;
    n = 0;
    while (!req_ready && n < 500) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R7 ready low after transfer", int'(req_ready), 0);
    n = 0;
    while (!rdata_valid && n < 200) begin @(negedge clk); n++; end
    check(rdata == pat(a[17:9], a[8:0]), late ? "R4 late data" : "R3 early data",
          int'(rdata), int'(pat(a[17:9], a[8:0])));
    check(acc_row == a[17:9], "R2 row half", int'(acc_row), int'(a[17:9]));
    check(acc_col == a[8:0], "R2 column half", int'(acc_col), int'(a[8:0]));
    if (late)
      check(!acc_early && cas_then_oe, "R4 cas before oe", int'({acc_early, cas_then_oe}), 1);
    else
      check(acc_early, "R3 oe before cas", int'(acc_early), 1);
    check(dram_ras_n && dram_cas_n && dram_oe_n, "R6 strobes high with valid",
          int'({dram_ras_n, dram_cas_n, dram_oe_n}), 7);
    @(negedge clk);
    check(!rdata_valid, "R6 single pulse", int'(rdata_valid), 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(dram_ras_n && dram_cas_n && dram_oe_n && dram_we_n, "R1 strobes in reset",
          int'({dram_ras_n, dram_cas_n, dram_oe_n, dram_we_n}), 15);
    check(!rdata_valid, "R1 valid in reset", int'(rdata_valid), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_early;
    do_read(18'h00000, 1'b0);
    do_read(18'h3FFFF, 1'b0);
    do_read(18'h12345, 1'b0);
    do_read(18'h2A5A5, 1'b0);
  endtask

  task automatic t_late;
    do_read(18'h00000, 1'b1);
    do_read(18'h3FFFF, 1'b1);
    do_read(18'h0F0F1, 1'b1);
    do_read(18'h2A5A5, 1'b1);
  endtask

  task automatic t_stream;
    int r0, c0;
    r0 = ref_cnt; c0 = cyc;
    for (int i = 0; i < 60; i++)
      do_read(18'((i * 18'h0A73B) ^ 18'h15555), i[0]);
    check(ref_cnt - r0 >= (cyc - c0) / REF - 1, "R11 refresh not starved",
          ref_cnt - r0, (cyc - c0) / REF - 1);
  endtask

  task automatic t_rules;
    check(pre_viol == 0, "R8 precharge gaps", pre_viol, 0);
    check(we_viol == 0, "R5 write enable high", we_viol, 0);
    check(oe_viol == 0, "R5 oe only inside ras", oe_viol, 0);
  endtask

  task automatic t_refresh;
    int n;
    n = 0;
    while (ref_cnt < 515 && n < 60000) begin @(negedge clk); n++; end
    check(ref_cnt >= 515, "R9 refresh count", ref_cnt, 515);
    check(ref_err == 0, "R9 R10 refresh shape and row order", ref_err, 0);
    check(wrapped, "R10 row wrap 511 to 0", int'(wrapped), 1);
    check(max_gap <= REF + SLACK, "R11 max refresh gap", max_gap, REF + SLACK);
    check(min_gap >= REF - SLACK, "R9 min refresh gap", min_gap, REF - SLACK);
    do_read(18'h1FE01, 1'b0);
  endtask

  initial begin
    t_reset;
    t_early;
    t_late;
    t_stream;
    t_rules;
    t_refresh;
    t_rules;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule